// File: doc/BRIEF.md
# Right-Justified Serial Audio Deserializer

This block turns an MSB-first serial audio stream into parallel left and right samples. Bits enter a fixed-width shift register on each bit strobe. There is no bit counter and no word framing. The register keeps shifting without pause, and the only thing that decides which bits become a sample is a transition on the channel-select level. When that level changes, the register contents are copied into the sample register of the channel that the edge names. In the cycle after the copy, a one-cycle valid pulse is raised for that channel.

The channel-select edge sits at the boundary between two channel slots. At that moment the register holds the last bits shifted in, which are the least significant end of a right-justified word. A source word wider than the register is cut down without any extra logic: its upper bits pass out of the top of the register and are lost. Padding or leftover bits from the previous slot are pushed out in the same way, as long as at least a register's width of new bits has arrived since them. With the default 16-bit register, a 32-bit slot carrying up to 24 data bits gives the low 16 bits of each word.

Top module: `rjust_deserializer`

## Requirements
- R1: Asynchronous active-low reset clears the shift register, both sample outputs and both valid pulses to zero. A channel-select edge before any bit strobe therefore latches zero.
- R2: On a cycle with `bitStrobe` high, the shift register moves one place toward its MSB and `serialIn` enters at bit 0. The serial stream is therefore MSB first.
- R3: On a cycle with `bitStrobe` low, the shift register holds, and `serialIn` has no effect on any later sample.
- R4: A rising edge of `chanSel` (0 then 1, compared with the previous cycle's sampled value, which is 0 after reset) copies the shift register into `sampleLeft` and raises `validLeft` for exactly the next cycle.
- R5: A falling edge of `chanSel` (1 then 0) copies the shift register into `sampleRight` and raises `validRight` for exactly the next cycle.
- R6: A right-justified word wider than DATA_W bits, ending at the slot boundary, is latched as its low DATA_W bits.
- R7: When a bit strobe and a `chanSel` edge occur in the same cycle, the latched sample is the register value from before that cycle's shift.
- R8: Each sample output changes only in a cycle where its own valid is high. The two valids are never high together.
- R9: Bits received more than DATA_W strobes before a latch, such as slot padding or the previous channel's tail, never appear in the latched sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitStrobe | input | 1 | Synchronous one-cycle enable, one per serial bit |
| serialIn | input | 1 | Serial data bit, sampled when bitStrobe is high |
| chanSel | input | 1 | Channel-select level; its edges trigger latches |
| sampleLeft | output | DATA_W | Last latched left sample |
| sampleRight | output | DATA_W | Last latched right sample |
| validLeft | output | 1 | One-cycle pulse after a left latch |
| validRight | output | 1 | One-cycle pulse after a right latch |

## Verification
The stimulus is random right-justified 32-strobe slots that alternate between channels and carry 16-, 20- and 24-bit words behind random padding. This tells correct capture of the low bits (R4, R5) apart from truncation errors (R6) and from padding leaking into a sample (R9). Idle cycles with random junk on the data line are scattered through each slot. They separate a gated shift from one that runs on every clock (R3). Some slots open with the channel edge on a strobe cycle and others on an idle cycle, which shows whether the pre-shift value is captured (R7). A cycle-level reference model also flags any change of a sample or valid outside its own edge (R8).

// File: rtl/rjd_pkg.sv
package rjd_pkg;
  typedef struct packed {
    logic shiftEn;
    logic latchLeft;
    logic latchRight;
  } rjdCtl_t;
endpackage

// File: rtl/rjd_ctrl.sv
module rjd_ctrl
  import rjd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitStrobe,
  input  logic    chanSel,
  output rjdCtl_t ctl
);
  logic prevSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSel <= 1'b0;
    else       prevSel <= chanSel;
  end

  always_comb begin
    ctl.shiftEn    = bitStrobe;
    ctl.latchLeft  = chanSel & ~prevSel;
    ctl.latchRight = ~chanSel & prevSel;
  end
endmodule

// File: rtl/rjd_datapath.sv
module rjd_datapath
  import rjd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  rjdCtl_t           ctl,
  output logic [DATA_W-1:0] sampleLeft,
  output logic [DATA_W-1:0] sampleRight,
  output logic              validLeft,
  output logic              validRight
);
  localparam int TOP = DATA_W - 1;

  logic [TOP:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[TOP-1:0], serialIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleLeft  <= '0;
      sampleRight <= '0;
      validLeft   <= 1'b0;
      validRight  <= 1'b0;
    end else begin
      validLeft  <= ctl.latchLeft;
      validRight <= ctl.latchRight;
      if (ctl.latchLeft)  sampleLeft  <= shiftReg;
      if (ctl.latchRight) sampleRight <= shiftReg;
    end
  end

  AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.shiftEn) |-> shiftReg[0] == $past(serialIn)); // R2
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.shiftEn) |-> shiftReg == $past(shiftReg)); // R3
  AST_LEFT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    validLeft |-> sampleLeft == $past(shiftReg)); // R7
  AST_RIGHT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    validRight |-> sampleRight == $past(shiftReg)); // R7
  AST_SINGLE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !(validLeft && validRight)); // R8
  AST_LEFT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !validLeft |-> sampleLeft == $past(sampleLeft)); // R8
  AST_RIGHT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !validRight |-> sampleRight == $past(sampleRight)); // R8
endmodule

// File: rtl/rjust_deserializer.sv
module rjust_deserializer
  import rjd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStrobe,
  input  logic              serialIn,
  input  logic              chanSel,
  output logic [DATA_W-1:0] sampleLeft,
  output logic [DATA_W-1:0] sampleRight,
  output logic              validLeft,
  output logic              validRight
);
  rjdCtl_t ctl;

  rjd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitStrobe (bitStrobe),
    .chanSel   (chanSel),
    .ctl       (ctl)
  );

  rjd_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .serialIn    (serialIn),
    .ctl         (ctl),
    .sampleLeft  (sampleLeft),
    .sampleRight (sampleRight),
    .validLeft   (validLeft),
    .validRight  (validRight)
  );

  AST_LEFT_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    validLeft |-> $past(chanSel)); // R4
  AST_RIGHT_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    validRight |-> !$past(chanSel)); // R5
endmodule

// File: tb/rjust_deserializer_test.sv
module rjust_deserializer_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStrobe = 1'b0;
  logic serialIn = 1'b0;
  logic chanSel = 1'b0;
  logic [W-1:0] sampleLeft, sampleRight;
  logic validLeft, validRight;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [W-1:0] mReg = '0, mLeft = '0, mRight = '0;
  logic mVL = 1'b0, mVR = 1'b0, mPrev = 1'b0;
  logic [23:0] prevWord = '0;
  bit havePrev = 0;

  always #4 clk = ~clk;

  rjust_deserializer #(.DATA_W(W)) uut (
    .clk(clk), .rstN(rstN), .bitStrobe(bitStrobe), .serialIn(serialIn),
    .chanSel(chanSel), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .validLeft(validLeft), .validRight(validRight)
  );

  function automatic logic [W-1:0] lowBits(input logic [23:0] word);
    return word[W-1:0];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic bs, input logic bitVal, input logic sel, input string tag);
    logic edgeSeen;
    @(negedge clk);
    bitStrobe = bs; serialIn = bitVal; chanSel = sel;
    edgeSeen = (sel != mPrev);
    mVL = edgeSeen && sel;
    mVR = edgeSeen && !sel;
    if (mVL) mLeft = mReg;
    if (mVR) mRight = mReg;
    if (bs) mReg = {mReg[W-2:0], bitVal};
    mPrev = sel;
    @(posedge clk); #1;
    check({tag, " left"}, sampleLeft, mLeft);
    check({tag, " right"}, sampleRight, mRight);
    check({tag, " valids"}, {14'd0, validLeft, validRight}, {14'd0, mVL, mVR});
  endtask

  task automatic sendSlot(input logic sel, input logic [23:0] word, input int nbits, input bit edgeOnIdle);
    string tag;
    int sent = 0;
    tag = (nbits > W) ? "R6" : (sel ? "R4" : "R5");
    if (edgeOnIdle) tick(1'b0, 1'($urandom), sel, "R3");
    else begin
      tick(1'b1, 1'($urandom), sel, "R7");
      sent = 1;
    end
    if (havePrev) begin
      if (sel) check({tag, " R9 slot latch"}, sampleLeft, lowBits(prevWord));
      else     check({tag, " R9 slot latch"}, sampleRight, lowBits(prevWord));
    end
    while (sent < 32) begin
      if ($urandom_range(0, 3) == 0) tick(1'b0, 1'($urandom), sel, "R3");
      else begin
        if (sent < 32 - nbits) tick(1'b1, 1'($urandom), sel, "R9");
        else tick(1'b1, word[31 - sent], sel, "R2");
        sent++;
      end
    end
    prevWord = word;
    havePrev = (nbits >= W);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset left", sampleLeft, '0);
    check("R1 reset right", sampleRight, '0);
    check("R1 reset valids", {14'd0, validLeft, validRight}, '0);
    @(negedge clk); rstN = 1'b1;
    tick(1'b0, 1'b1, 1'b1, "R1");
    check("R1 cleared register", sampleLeft, '0);
    tick(1'b0, 1'b1, 1'b0, "R1");
    tick(1'b1, 1'b1, 1'b1, "R7");
    check("R7 pre-shift capture", sampleLeft, '0);
    tick(1'b1, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 40; i++) begin
      int nb;
      logic [23:0] w;
      nb = (i % 3 == 0) ? 16 : ((i % 3 == 1) ? 20 : 24);
      w = 24'($urandom);
      if (nb < 24) w = w & ((24'd1 << nb) - 24'd1);
      sendSlot(i[0] ? 1'b0 : 1'b1, w, nb, ($urandom_range(0, 1) == 1));
    end
    tick(1'b0, 1'b0, ~chanSel, "R8");
    tick(1'b0, 1'b0, chanSel, "R8");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule